// File: doc/BRIEF.md
# Aligned Transfer Piece Sequencer

This block splits a byte-addressed memory access into a series of naturally aligned pieces, ready for a serial link that can move 2-byte, 4-byte or multi-word burst units. A request gives a start address, a byte count and a direction. The block then presents one piece at a time: its command opcode, its address, its length and its offset from the start of the access. Each piece waits until the consumer accepts it with a valid/ready handshake.

The piece size is chosen from the low three address bits and the bytes still to move. Short or misaligned pieces are used until the address reaches an 8-byte boundary. After that, bursts are used, each a multiple of 8 bytes and no longer than a fixed cap. This gives few pieces while every piece starts on a boundary of its own size. Requests that cannot be aligned are rejected with an error strobe. Odd-length writes are padded by one trailing byte.

Top module: `aligned_piece_seq`

## Requirements
- R1: The opcode is 0 or 1 for a 2-byte piece, 2 or 3 for a 4-byte piece, and 4 or 5 for a burst piece. Bit 0 is 1 for a write and 0 for a read, so each write code is its read code plus one.
- R2: A 2-byte piece is chosen when the piece address modulo 8 is 2 or 6, or when exactly 2 bytes remain.
- R3: If R2 does not apply, a 4-byte piece is chosen when the piece address modulo 8 is 4, or when 6 or fewer bytes remain.
- R4: In all other cases, a burst piece is chosen. Its length is the remaining count rounded down to a multiple of 8, limited to BURST_MAX (240) bytes.
- R5: Every piece address is a multiple of its own length, with bursts on 8-byte boundaries.
- R6: A start with an odd address, in either direction, raises `err` for one cycle in the next cycle. No piece is issued and `done` stays low.
- R7: A read start with an odd length is rejected as in R6. A write with an odd length is handled as length+1, so the pieces cover one extra trailing byte.
- R8: While `pc_valid` is high and `pc_ready` is low, every piece output holds its value. After each accepted piece, the address and the offset both advance by the piece length.
- R9: `done` pulses for one cycle in the cycle after the last piece is accepted. A zero-length start pulses `done` in the next cycle and issues no piece.
- R10: A `start` that arrives while `busy` is high is ignored. This includes the cycle in which the last piece is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| start_rd | input | 1 | 1 = read, 0 = write |
| start_addr | input | ADDR_W | Byte start address |
| start_len | input | CNT_W | Byte count |
| pc_ready | input | 1 | Consumer accepts the current piece |
| pc_valid | output | 1 | A piece is presented |
| pc_op | output | 3 | Piece opcode |
| pc_addr | output | ADDR_W | Piece byte address |
| pc_len | output | CNT_W+1 | Piece length in bytes |
| pc_offset | output | CNT_W+1 | Piece offset from the start of the access |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle rejection strobe |

## Verification
The two functions that can fall in the same cycle are the acceptance of the final piece and a new `start` request. While the last piece is being taken, `busy` is still high, so the new start must be dropped. The bench provokes this on a regular fraction of a full sweep: it asserts a different request exactly on the final accepting edge. In the following cycle it expects `done` high, with `pc_valid`, `busy` and `err` all low. The sweep covers both directions, every address modulo 8 and every length from 0 to 263, against randomly stalled ready. Each piece is compared with an arithmetic model of the selection rules.

// File: rtl/aligned_piece_seq.sv
module aligned_piece_seq #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BURST_MAX = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              pc_ready,
  output logic              pc_valid,
  output logic [2:0]        pc_op,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [CNT_W:0]    pc_len,
  output logic [CNT_W:0]    pc_offset,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int RW = CNT_W + 1;

  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RW-1:0]     rem_q, off_q;

  wire [2:0]    al     = addr_q[2:0];
  wire          sel2   = (al == 3'd2) || (al == 3'd6) || (rem_q == RW'(2));
  wire          sel4   = (al == 3'd4) || (rem_q <= RW'(6));
  wire [RW-1:0] floor8 = rem_q & ~RW'(7);
  wire [RW-1:0] blen   = (floor8 > RW'(BURST_MAX)) ? RW'(BURST_MAX) : floor8;

  assign pc_len    = sel2 ? RW'(2) : (sel4 ? RW'(4) : blen);
  assign pc_op     = {~sel2 & ~sel4, ~sel2 & sel4, ~rd_q};
  assign pc_valid  = busy;
  assign pc_addr   = addr_q;
  assign pc_offset = off_q;

  wire          bad    = start_addr[0] | (start_rd & start_len[0]);
  wire [RW-1:0] padded = {1'b0, start_len} + RW'(start_len[0]);
  wire          fire   = pc_valid & pc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      off_q  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (bad) err <= 1'b1;
          else if (padded == '0) done <= 1'b1;
          else begin
            busy   <= 1'b1;
            rd_q   <= start_rd;
            addr_q <= start_addr;
            rem_q  <= padded;
            off_q  <= '0;
          end
        end
      end else if (fire) begin
        addr_q <= addr_q + ADDR_W'(pc_len);
        rem_q  <= rem_q - pc_len;
        off_q  <= off_q + pc_len;
        if (rem_q == pc_len) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module aligned_piece_chk #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BURST_MAX = 240
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_ready,
  input logic              pc_valid,
  input logic [2:0]        pc_op,
  input logic [ADDR_W-1:0] pc_addr,
  input logic [CNT_W:0]    pc_len,
  input logic [CNT_W:0]    pc_offset,
  input logic              done,
  input logic              err
);
  localparam int RW = CNT_W + 1;

  p_op_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> (pc_op <= 3'd5));

  p_op_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> ((pc_op[2:1] == 2'd0) == (pc_len == RW'(2))));

  p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> (pc_len == RW'(2) || pc_len == RW'(4) ||
                  (pc_len[2:0] == 3'd0 && pc_len >= RW'(8) && pc_len <= RW'(BURST_MAX))));

  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> ((pc_len == RW'(2) && !pc_addr[0]) ||
                  (pc_len == RW'(4) && pc_addr[1:0] == 2'd0) ||
                  (pc_len >= RW'(8) && pc_addr[2:0] == 3'd0)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && !pc_ready) |=> (pc_valid && $stable(pc_addr) && $stable(pc_len) &&
                                 $stable(pc_op) && $stable(pc_offset)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pc_valid && !err));

  p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !pc_valid);
endmodule

bind aligned_piece_seq aligned_piece_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_MAX(BURST_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_ready(pc_ready), .pc_valid(pc_valid),
  .pc_op(pc_op), .pc_addr(pc_addr), .pc_len(pc_len), .pc_offset(pc_offset),
  .done(done), .err(err)
);

// File: tb/sim_aligned_piece_seq.sv
`timescale 1ns/1ps
module sim_aligned_piece_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, start_rd = 1'b0, pc_ready = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] start_len = '0;
  logic        pc_valid, busy, done, err;
  logic [2:0]  pc_op;
  logic [31:0] pc_addr;
  logic [16:0] pc_len, pc_offset;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  aligned_piece_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .start_addr(start_addr), .start_len(start_len), .pc_ready(pc_ready),
    .pc_valid(pc_valid), .pc_op(pc_op), .pc_addr(pc_addr), .pc_len(pc_len),
    .pc_offset(pc_offset), .busy(busy), .done(done), .err(err)
  );

  function automatic int exp_len(int a, int rem);
    if (a == 2 || a == 6 || rem == 2) return 2;
    else if (a == 4 || rem <= 6) return 4;
    else begin
      int f = rem - (rem % 8);
      return (f > 240) ? 240 : f;
    end
  endfunction

  function automatic int exp_op(int l, bit rd);
    return ((l == 2) ? 0 : (l == 4) ? 2 : 4) + (rd ? 0 : 1);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(bit rd, logic [31:0] addr, int len, bit inject);
    int   erem, eoff, el, eo;
    logic [31:0] ea;
    bit   rdy, last;
    @(negedge clk);
    start = 1'b1; start_rd = rd; start_addr = addr; start_len = 16'(len);
    @(posedge clk);
    if (addr[0] || (rd && len[0])) begin
      @(negedge clk);
      start = 1'b0;
      // R6 / R7: rejected, no piece, no done
      check(err && !pc_valid && !done && !busy, addr[0] ? "R6" : "R7", "reject",
            {err, pc_valid, done, busy}, 4'b1000);
      return;
    end
    erem = len + (len % 2);
    if (erem == 0) begin
      @(negedge clk);
      start = 1'b0;
      check(done && !pc_valid && !err && !busy, "R9", "zero-length done",
            {done, pc_valid, err, busy}, 4'b1000);
      return;
    end
    ea = addr; eoff = 0;
    while (erem > 0) begin
      @(negedge clk);
      start = 1'b0;
      el = exp_len(int'(ea[2:0]), erem);
      eo = exp_op(el, rd);
      check(pc_valid === 1'b1 && busy === 1'b1, "R8", "valid", pc_valid, 1);
      check(int'(pc_len) == el, (el == 2) ? "R2" : (el == 4) ? "R3" : "R4", "len",
            pc_len, el);
      check(int'(pc_op) == eo, "R1", "op", pc_op, eo);
      check(pc_addr === ea && int'(pc_offset) == eoff, "R8", "addr/offset",
            {pc_addr, 15'd0, pc_offset}, {ea, 15'd0, 17'(eoff)});
      check((pc_addr & (32'((el > 8) ? 8 : el) - 32'd1)) == 32'd0, "R5", "alignment",
            pc_addr, ea);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy  = (lfsr[1:0] != 2'b00);
      last = rdy && (erem == el);
      pc_ready = rdy;
      if (last && inject) begin
        start = 1'b1; start_rd = ~rd; start_addr = 32'h0; start_len = 16'd16;
      end
      @(posedge clk);
      if (rdy) begin
        ea = ea + 32'(el); eoff += el; erem -= el;
      end
    end
    @(negedge clk);
    start = 1'b0; pc_ready = 1'b0;
    check(done && !pc_valid && !busy && !err, inject ? "R10" : "R9", "completion",
          {done, pc_valid, busy, err}, 4'b1000);
    // R7: write pieces cover the padded length
    if (!rd && len[0]) check(eoff == len + 1, "R7", "pad total", eoff, len + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pc_valid && !busy && !done && !err, "R9", "reset state",
          {pc_valid, busy, done, err}, 0);
    rst_n = 1'b1;
    run_xfer(1'b1, 32'h6003_0002, 260, 1'b0);
    run_xfer(1'b0, 32'h6003_0002, 260, 1'b1);
    for (int rd = 0; rd < 2; rd++)
      for (int a = 0; a < 8; a++)
        for (int len = 0; len < 264; len++)
          run_xfer(rd[0], 32'h6003_00F0 + 32'(a), len, (len % 5) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule